// File: doc/BRIEF.md
# Parallel Port Extended Control Register

This block is the host-visible extended control register of an enhanced parallel port. A single 8-bit register holds a three-bit transfer-mode field, an interrupt mask, a DMA enable and a service bit. The mode field is decoded for the port's datapath. The enable and service bits gate the DMA request toward the system DMA controller and qualify the acknowledge that comes back. The peripheral's active-low error line is synchronised and turned into a level interrupt for the host.

The host writes the register with `wr_en` and `wdata`. `rdata` always shows the stored value. A cycle with `rd_en` high is a register read and acknowledges any pending interrupt. The DMA request has no tri-state pin at this boundary. It leaves as a value (`drq`) plus an output enable (`drq_oe`), and the pad logic turns these into a high-impedance driver.

The interrupt is controlled by a two-state machine. IRQ_IDLE moves to IRQ_PEND on a trigger. A trigger is either a synchronised high-to-low edge of ERR while the mask is clear, or a write that clears a set mask while the synchronised ERR is low. IRQ_PEND moves back to IRQ_IDLE on a read cycle that carries no new trigger. In every other case IRQ_PEND stays where it is. `irq` is high exactly in IRQ_PEND.

Top module: `ppx_ctl_reg`

## Requirements
- R1: After reset, `rdata` is 0x10: mode 000, mask set, DMA disabled, service bit clear. `mode` is 000, `irq` is 0 and `drq_oe` is 0.
- R2: Bits 7:5 hold the mode. The codes are 000 standard, 001 byte-bidirectional, 010 compatible FIFO, 011 extended FIFO, 100 address/data strobe, 110 FIFO test and 111 configuration. They show on `mode` one cycle after the write.
- R3: Bits 1:0 always read as 0. Writing 1s to them has no effect.
- R4: While bit 3 (DMA enable) is 0, `drq_oe` and `drq` are 0, and `dack_ok` is 0 whatever `dack` is.
- R5: While bit 3 is 1, `drq_oe` is 1 and `dack_ok` follows `dack`. `drq` follows `fifo_req` only while bit 2 (service) is 0, and is held at 0 while bit 2 is 1.
- R6: With bit 4 (mask) at 0, a high-to-low change on `err_n` sets `irq` at the third rising clock edge after the change. The two synchroniser flops account for two of those edges.
- R7: A write that changes bit 4 from 1 to 0 while the synchronised `err_n` is low sets `irq` at that write's clock edge.
- R8: While bit 4 is 1, a falling `err_n` never sets `irq`.
- R9: Once set, `irq` stays high until a cycle with `rd_en` high clears it. If a trigger falls in that same read cycle, the trigger wins and `irq` stays high.
- R10: A rising `err_n` does not set `irq`, and clearing the mask while the synchronised `err_n` is high does not set `irq`.
- R11: Code 101 is stored and read back as written, but `mode` reports it as 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe; acknowledges the interrupt |
| rdata | output | 8 | Current register value |
| mode | output | 3 | Decoded transfer mode |
| err_n | input | 1 | Peripheral error, active low, asynchronous |
| irq | output | 1 | Interrupt level |
| fifo_req | input | 1 | Datapath wants a DMA transfer |
| drq | output | 1 | DMA request value |
| drq_oe | output | 1 | DMA request driver enable (0 = high impedance) |
| dack | input | 1 | DMA acknowledge from the controller |
| dack_ok | output | 1 | Qualified acknowledge to the datapath |

## Verification
The assertions check, on every cycle, the following behaviours:
- The DMA gating follows the enable and service bits.
- `mode` never reports the unassigned code, and the reserved bits read as zero.
- A qualified ERR edge or an unmask-while-low write moves the interrupt machine to IRQ_PEND on the next edge.
- A set mask keeps the machine idle, and a pending interrupt holds until a read.

Only the bench's scenarios can show the absolute latency from an ERR pin change through the synchroniser to `irq`. The same goes for the exact register images read back for each mode code, and for the read-versus-new-trigger collision ordering.

// File: rtl/ppx_pkg.sv
package ppx_pkg;

    localparam int REG_W   = 8;
    localparam int MODE_W  = 3;
    localparam int RSVD_W  = REG_W - MODE_W - 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_COMPAT      = 3'b000,
        MODE_BYTE_BIDIR  = 3'b001,
        MODE_FIFO_COMPAT = 3'b010,
        MODE_FIFO_EXT    = 3'b011,
        MODE_ADDR_DATA   = 3'b100,
        MODE_FIFO_TEST   = 3'b110,
        MODE_CONFIG      = 3'b111
    } mode_e;

    localparam logic [MODE_W-1:0] MODE_UNASSIGNED = 3'b101;

    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              mask;
        logic              dma_en;
        logic              svc;
        logic [RSVD_W-1:0] rsvd;
    } ctl_reg_t;

    localparam ctl_reg_t CTL_RESET = '{mode: '0, mask: 1'b1, dma_en: 1'b0,
                                       svc: 1'b0, rsvd: '0};

endpackage

// File: rtl/ppx_err_sync.sv
module ppx_err_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic err_n_async,
    output logic err_low,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= err_n_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[LAST];
    end

    always_comb begin
        err_low = ~chain_q[LAST];
        fall    = prev_q & ~chain_q[LAST];
    end

endmodule

// File: rtl/ppx_irq_fsm.sv
module ppx_irq_fsm
    import ppx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fall_i,
    input  logic err_low_i,
    input  logic mask_q_i,
    input  logic wr_i,
    input  logic wmask_i,
    input  logic rd_i,
    output logic irq_o
);
    irq_state_e state_q, state_d;
    logic       edge_trig, unmask_trig, trig;

    always_comb begin
        edge_trig   = fall_i & ~mask_q_i;
        unmask_trig = wr_i & mask_q_i & ~wmask_i & err_low_i;
        trig        = edge_trig | unmask_trig;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (trig)          state_d = IRQ_PEND;
            IRQ_PEND: if (rd_i && !trig) state_d = IRQ_IDLE;
            default:                     state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_o = (state_q == IRQ_PEND);
    end

    p_edge_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_i && !mask_q_i) |=> irq_o);

    p_unmask_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && mask_q_i && !wmask_i && err_low_i) |=> irq_o);

    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && mask_q_i && !(wr_i && !wmask_i)) |=> !irq_o);

    p_hold_until_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !rd_i) |=> irq_o);

endmodule

// File: rtl/ppx_dma_gate.sv
module ppx_dma_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic dma_en_i,
    input  logic svc_i,
    input  logic fifo_req_i,
    input  logic dack_i,
    output logic drq_o,
    output logic drq_oe_o,
    output logic dack_ok_o
);
    always_comb begin
        drq_oe_o  = dma_en_i;
        drq_o     = dma_en_i & ~svc_i & fifo_req_i;
        dack_ok_o = dma_en_i & dack_i;
    end

    p_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !drq_oe_o |-> (!drq_o && !dack_ok_o));

    p_svc_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en_i && svc_i) |-> !drq_o);

endmodule

// File: rtl/ppx_ctl_reg.sv
module ppx_ctl_reg
    import ppx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wdata,
    input  logic              rd_en,
    output logic [REG_W-1:0]  rdata,
    output logic [MODE_W-1:0] mode,
    input  logic              err_n,
    output logic              irq,
    input  logic              fifo_req,
    output logic              drq,
    output logic              drq_oe,
    input  logic              dack,
    output logic              dack_ok
);
    ctl_reg_t ctl_q;
    ctl_reg_t wr_img;
    logic     err_low, err_fall;

    always_comb begin
        wr_img      = ctl_reg_t'(wdata);
        wr_img.rsvd = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl_q <= CTL_RESET;
        else if (wr_en)  ctl_q <= wr_img;
    end

    always_comb begin
        rdata = ctl_q;
        if (ctl_q.mode == MODE_UNASSIGNED) mode = MODE_COMPAT;
        else                                mode = ctl_q.mode;
    end

    ppx_err_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .err_n_async (err_n),
        .err_low     (err_low),
        .fall        (err_fall)
    );

    ppx_irq_fsm u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_i    (err_fall),
        .err_low_i (err_low),
        .mask_q_i  (ctl_q.mask),
        .wr_i      (wr_en),
        .wmask_i   (wr_img.mask),
        .rd_i      (rd_en),
        .irq_o     (irq)
    );

    ppx_dma_gate u_dma (
        .clk        (clk),
        .rst_n      (rst_n),
        .dma_en_i   (ctl_q.dma_en),
        .svc_i      (ctl_q.svc),
        .fifo_req_i (fifo_req),
        .dack_i     (dack),
        .drq_o      (drq),
        .drq_oe_o   (drq_oe),
        .dack_ok_o  (dack_ok)
    );

    p_no_unassigned_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mode != MODE_UNASSIGNED);

    p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[RSVD_W-1:0] == '0);

    p_mode_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[7:5] != MODE_UNASSIGNED) |=> mode == $past(wdata[7:5]));

endmodule

// File: tb/ppx_ctl_reg_bench.sv
module ppx_ctl_reg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic [2:0] mode;
    logic       err_n = 1'b1;
    logic       irq;
    logic       fifo_req = 1'b0;
    logic       drq, drq_oe;
    logic       dack = 1'b0;
    logic       dack_ok;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ppx_ctl_reg u_ppx_ctl_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
        .rdata(rdata), .mode(mode), .err_n(err_n), .irq(irq),
        .fifo_req(fifo_req), .drq(drq), .drq_oe(drq_oe), .dack(dack),
        .dack_ok(dack_ok)
    );

    // {wdata, expected rdata, mode, drq_oe, drq, dack_ok}, fifo_req=dack=1
    localparam logic [21:0] VEC [8] = '{
        {8'h10, 8'h10, 3'd0, 1'b0, 1'b0, 1'b0},
        {8'h38, 8'h38, 3'd1, 1'b1, 1'b1, 1'b1},
        {8'h5C, 8'h5C, 3'd2, 1'b1, 1'b0, 1'b1},
        {8'h7B, 8'h78, 3'd3, 1'b1, 1'b1, 1'b1},
        {8'h90, 8'h90, 3'd4, 1'b0, 1'b0, 1'b0},
        {8'hB8, 8'hB8, 3'd0, 1'b1, 1'b1, 1'b1},
        {8'hD4, 8'hD4, 3'd6, 1'b0, 1'b0, 1'b0},
        {8'hFF, 8'hFC, 3'd7, 1'b1, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wdata = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cycles(2);
        rst_n = 1'b1;
        cycles(1);
        check("R1 rdata", rdata, 8'h10);
        check("R1 mode", {5'd0, mode}, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 drq_oe", {7'd0, drq_oe}, 8'h00);

        fifo_req = 1'b1; dack = 1'b1;
        for (int k = 0; k < 8; k++) begin
            wr(VEC[k][21:14]);
            check("R2/R3/R11 rdata", rdata, VEC[k][13:6]);
            check("R2/R11 mode", {5'd0, mode}, {5'd0, VEC[k][5:3]});
            check("R4/R5 drq_oe", {7'd0, drq_oe}, {7'd0, VEC[k][2]});
            check("R4/R5 drq", {7'd0, drq}, {7'd0, VEC[k][1]});
            check("R4/R5 dack_ok", {7'd0, dack_ok}, {7'd0, VEC[k][0]});
        end
        // R5: drq follows fifo_req with service bit clear
        wr(8'h38);
        fifo_req = 1'b0; #1;
        check("R5 drq tracks fifo_req", {7'd0, drq}, 8'h00);
        dack = 1'b0; #1;
        check("R5 dack_ok tracks dack", {7'd0, dack_ok}, 8'h00);

        // R8: masked, falling ERR ignored
        wr(8'h10);
        err_n = 1'b0;
        cycles(5);
        check("R8 masked edge", {7'd0, irq}, 8'h00);
        // R7: unmask while ERR low
        wr(8'h00);
        check("R7 unmask while low", {7'd0, irq}, 8'h01);
        cycles(4);
        check("R9 level held", {7'd0, irq}, 8'h01);
        rd();
        check("R9 read clears", {7'd0, irq}, 8'h00);
        // R10: rising ERR, then unmask while high
        err_n = 1'b1;
        cycles(5);
        check("R10 rising edge", {7'd0, irq}, 8'h00);
        wr(8'h10);
        wr(8'h00);
        check("R10 unmask while high", {7'd0, irq}, 8'h00);

        // R6: edge latency, mask clear
        err_n = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R6 not before third edge", {7'd0, irq}, 8'h00);
        @(negedge clk);
        check("R6 third edge", {7'd0, irq}, 8'h01);
        rd();
        check("R9 clear again", {7'd0, irq}, 8'h00);

        // R9: trigger in same cycle as read wins
        err_n = 1'b1;
        cycles(4);
        err_n = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R9 trigger beats read", {7'd0, irq}, 8'h01);
        rd();
        check("R9 final clear", {7'd0, irq}, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule